// File: doc/BRIEF.md
# Two-Byte Converter Result Read Port

This block is the processor-facing read side of a 10-bit data converter. A conversion engine presents a finished 10-bit word with a one-cycle load strobe. The block captures it in a result latch and raises an end-of-conversion interrupt. A host on an 8-bit bus then reads the word as two bytes in a row. The first byte is the upper eight result bits, left-justified. The second byte carries the two lowest bits at the top of the byte, with zeros below them.

The host's active-low chip select and read lines are asynchronous to the block clock, so each passes through a two-stage synchroniser before use. When both synchronised strobes are low, the bus drivers are enabled and the interrupt flag is cleared. A load opens a set window of a parameterised number of clocks, and during that window setting the flag wins over clearing it. A host that holds its read enable low all the time therefore still sees an interrupt pulse at each end of conversion. The interrupt output can also be tied back to a start input so the converter runs freely.

Top module: `adc_rd_port`

## Requirements
- R1: After reset the interrupt output is high, the output enable is low, and the byte pointer selects the high byte.
- R2: While a read is active, the first read after a load drives result bits 9..2 on data lines 7..0.
- R3: The second read after a load drives result bit 1 on data line 7 and bit 0 on data line 6, with data lines 5..0 at zero.
- R4: The byte pointer toggles when an active read ends (the synchronised read enable rises), so a third read returns the high byte again.
- R5: The output enable is high only while synchronised chip select and read are both low, and it follows the pins with a two-clock synchroniser delay. At all other times the data output is zero.
- R6: A load strobe drives the interrupt output low one clock after the strobe and resets the byte pointer to the high byte.
- R7: While no set window is open, an active read returns the interrupt output high one clock after the read becomes active in synchronised form.
- R8: For SET_CYC clocks after a load, the interrupt stays low even while a read is active. After the window it is cleared if the read is still active.
- R9: Chip select alone, or read alone, does not enable the bus, clear the interrupt or move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select, asynchronous |
| rd_ni | input | 1 | Active-low read strobe, asynchronous |
| load_i | input | 1 | One-cycle result load strobe from the conversion engine |
| result_i | input | 10 | Converted word captured on load |
| data_o | output | 8 | Bus data, zero when not driven |
| data_oe_o | output | 1 | Bus driver enable for the tri-state pads |
| intr_no | output | 1 | Active-low end-of-conversion interrupt |

## Verification
A byte pointer left in the wrong state shows up on the very next read as the wrong byte layout: a byte with its low six bits set where padding was expected, or a lone pair of bits where the high byte was expected. A broken set window shows up when the read enable is held low through a load. In that case the interrupt either never falls or stays low past SET_CYC clocks, and the bench measures this to the exact cycle. A fault in the synchroniser or the enable logic shifts the output enable by a cycle, or enables it on a single strobe, and this is visible in the first cycle concerned.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned RES_W  = 10;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned SYNC_N = 2;
  typedef enum logic {BYTE_HI = 1'b0, BYTE_LO = 1'b1} byte_sel_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '1;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_rd_flag.sv
module adc_rd_flag #(
  parameter int unsigned SET_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int unsigned CNT_W = (SET_CYC < 2) ? 1 : $clog2(SET_CYC + 1);

  logic [CNT_W-1:0] win_q;
  logic             set_act;

  assign set_act = load_i || (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else if (load_i) win_q <= CNT_W'(SET_CYC - 1);
    else if (win_q != '0) win_q <= win_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else if (set_act) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R6
  load_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> flag_o);
  // R8
  window_holds_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |=> flag_o);
endmodule

// File: rtl/adc_rd_mux.sv
module adc_rd_mux
  import adc_rd_pkg::*;
(
  input  logic [RES_W-1:0] res_i,
  input  byte_sel_e        sel_i,
  input  logic             oe_i,
  output logic [BUS_W-1:0] data_o
);
  localparam int unsigned LO_N = RES_W - BUS_W;

  logic [BUS_W-1:0] hi_b, lo_b;
  assign hi_b = res_i[RES_W-1 -: BUS_W];
  assign lo_b = {res_i[LO_N-1:0], {(BUS_W-LO_N){1'b0}}};

  always_comb begin
    data_o = '0;
    if (oe_i) data_o = (sel_i == BYTE_HI) ? hi_b : lo_b;
  end

  // R3
  pad_zero_chk: assert final (!(oe_i && sel_i == BYTE_LO) || data_o[BUS_W-LO_N-1:0] == '0);
endmodule

// File: rtl/adc_rd_port.sv
module adc_rd_port
  import adc_rd_pkg::*;
#(
  parameter int unsigned SET_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe_o,
  output logic             intr_no
);
  logic [1:0]       sync_q;
  logic             cs_s, rd_s, rd_en, rd_en_q;
  logic [RES_W-1:0] res_q;
  byte_sel_e        sel_q;
  logic             flag;

  adc_rd_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({cs_ni, rd_ni}), .q_o(sync_q));

  assign cs_s  = sync_q[1];
  assign rd_s  = sync_q[0];
  assign rd_en = !cs_s && !rd_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q <= 1'b0;
      res_q   <= '0;
      sel_q   <= BYTE_HI;
    end else begin
      rd_en_q <= rd_en;
      if (load_i) begin
        res_q <= result_i;
        sel_q <= BYTE_HI;
      end else if (rd_en_q && !rd_en) begin
        sel_q <= (sel_q == BYTE_HI) ? BYTE_LO : BYTE_HI;
      end
    end
  end

  adc_rd_flag #(.SET_CYC(SET_CYC)) u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .clr_i(rd_en), .flag_o(flag));

  adc_rd_mux u_mux (.res_i(res_q), .sel_i(sel_q), .oe_i(rd_en), .data_o(data_o));

  assign data_oe_o = rd_en;
  assign intr_no   = !flag;

  // R5
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
  // R4
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_s) && !cs_s && !load_i) |=> sel_q != $past(sel_q));
  // R9
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_q && !load_i) |=> $stable(sel_q));
endmodule

// File: tb/sim_adc_rd_port.sv
`timescale 1ns/1ps
module sim_adc_rd_port;
  localparam int SET_CYC = 4;
  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, load = 0;
  logic [9:0] res = '0;
  logic [7:0] data;
  logic oe, intr_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  adc_rd_port #(.SET_CYC(SET_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .load_i(load),
    .result_i(res), .data_o(data), .data_oe_o(oe), .intr_no(intr_n));

  function automatic logic [7:0] hi_of(logic [9:0] r); return r[9:2]; endfunction
  function automatic logic [7:0] lo_of(logic [9:0] r); return {r[1:0], 6'b0}; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(posedge clk); #2; endtask

  task automatic do_load(logic [9:0] v);
    @(negedge clk); res = v; load = 1;
    @(negedge clk); load = 0;
  endtask

  // read: drive low, wait sync (2) + margin, sample, release, settle
  task automatic do_read(output logic [7:0] b);
    @(negedge clk); cs_n = 0; rd_n = 0;
    cyc(3); b = data;
    @(negedge clk); cs_n = 1; rd_n = 1;
    cyc(4);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd1234));
    #23 rst_n = 1;
    cyc(2);
    // R1
    chk("R1 intr", intr_n, 1); chk("R1 oe", oe, 0); chk("R1 data", data, 0);

    // R6 load drives intr low next cycle
    @(negedge clk); res = 10'h2C5; load = 1;
    @(posedge clk); #2; chk("R6 intr after load", intr_n, 0);
    @(negedge clk); load = 0;
    cyc(SET_CYC + 2);

    // R5 sync latency
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(posedge clk); #2; chk("R5 oe after 1 clk", oe, 0);
    @(posedge clk); #2; chk("R5 oe after 2 clk", oe, 1);
    // R2 first byte; R7 intr cleared one clock later
    chk("R2 high byte", data, hi_of(10'h2C5));
    @(posedge clk); #2; chk("R7 intr cleared", intr_n, 1);
    @(negedge clk); cs_n = 1; rd_n = 1;
    cyc(4); chk("R5 oe idle", oe, 0); chk("R5 data idle", data, 0);
    do_read(b); chk("R3 low byte", b, lo_of(10'h2C5));
    do_read(b); chk("R4 wrap to high", b, hi_of(10'h2C5));

    // R9 single strobes
    do_load(10'h3FF);
    @(negedge clk); cs_n = 0; cyc(4);
    chk("R9 cs alone oe", oe, 0); chk("R9 cs alone intr", intr_n, 0);
    @(negedge clk); cs_n = 1; rd_n = 0; cyc(4);
    chk("R9 rd alone oe", oe, 0); chk("R9 rd alone intr", intr_n, 0);
    @(negedge clk); rd_n = 1; cyc(3);
    do_read(b); chk("R9 pointer unmoved", b, hi_of(10'h3FF));
    // R6 load resets pointer mid-sequence
    do_load(10'h001);
    do_read(b); chk("R6 pointer reset", b, hi_of(10'h001));
    do_read(b); chk("R3 low pad", b, lo_of(10'h001));

    // R8 read held active through a load
    @(negedge clk); cs_n = 0; rd_n = 0; cyc(4);
    chk("R8 intr high pre", intr_n, 1);
    @(negedge clk); res = 10'h155; load = 1;
    @(posedge clk); #2;
    for (int i = 0; i < SET_CYC; i++) begin
      chk("R8 intr low in window", intr_n, 0);
      if (i == 0) begin @(negedge clk); load = 0; @(posedge clk); #2; end
      else begin @(posedge clk); #2; end
    end
    chk("R8 intr cleared after window", intr_n, 1);
    chk("R2 held read sees new high", data, hi_of(10'h155));
    @(negedge clk); cs_n = 1; rd_n = 1; cyc(4);
    do_read(b); chk("R3 after held read", b, lo_of(10'h155));

    // random results
    for (int k = 0; k < 40; k++) begin
      logic [9:0] v = 10'($urandom);
      do_load(v);
      cyc(SET_CYC);
      chk("R6 intr low", intr_n, 0);
      do_read(b); chk("R2 random high", b, hi_of(v));
      chk("R7 intr high", intr_n, 1);
      do_read(b); chk("R3 random low", b, lo_of(v));
      if ($urandom % 2) begin do_read(b); chk("R4 random wrap", b, hi_of(v)); end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule